// File: doc/BRIEF.md
# Hint-Driven Instruction Fetch Unit

This block is the instruction fetch front end of a processor core that has no hardware branch predictor. Sequential instructions come from a small prefetch queue that is kept topped up from the running fetch address. A taken branch is redirected only when software has issued a hint command beforehand. The command names the address of a branch and the address it will jump to. One hint register holds that pair, and a four-word target buffer is pre-loaded from the jump address.

When the fetch stage delivers the word whose address equals the hinted branch, the next four words come from the target buffer, at the jump address and the three words after it. Sequential fetch then resumes right after the last buffered word. The prefetch queue is discarded at the switch and starts refilling from that resume address while the buffered words are being consumed. Both buffers share one instruction memory read port with a fixed two-cycle latency, and target-buffer loads win that port.

A hint issued too late still redirects correctly, but fetch stalls until each missing target word arrives. A hint stays armed after it is used, so a loop branch is redirected on every pass until a newer hint replaces it.

Top module: `hint_fetch_unit`

## Requirements
- R1: A hint command sampled at a clock edge writes the branch and jump addresses at that edge. In the very next cycle the memory port requests the jump address, and the following three cycles request jump+4, jump+8 and jump+12.
- R2: Without a redirect, fetch delivers consecutive words at addresses that rise by 4 from the reset address. Each delivered word equals the memory content at its address, and an offered word is held stable until it is taken (fetch_valid_o and fetch_ready_i both high).
- R3: When the word at the hinted branch address is taken, the next four words delivered are the jump address plus 0, 4, 8 and 12, with fetch_from_hint_o high. After them, fetch_from_hint_o goes low and sequential fetch continues from jump+16.
- R4: If a target word has not yet arrived when it is due, fetch_valid_o stays low until it does. The word is then delivered with the correct address and content.
- R5: A new hint command replaces the previous one. The old branch address no longer redirects, and the old target words are never delivered.
- R6: While target words remain to be loaded, every memory request is a target-buffer load and not a sequential prefetch. Read data returns two cycles after its request.
- R7: Fetching addresses that do not match the hinted branch leaves the hint armed. A branch reached again, for example at the bottom of a loop, is redirected again on each pass.
- R8: The prefetch queue holds 8 words. With fetch_ready_i held low from reset and no hint, exactly 8 memory requests are issued and then requests stop.
- R9: During reset fetch_valid_o and fetch_from_hint_o are low and no hint is armed. The first word offered after reset is at the reset address.
- R10: A hint command that arrives while target words are being delivered ends the redirect. Fetch continues sequentially from the address that follows the last word taken, and the new hint is armed. A hint command in the same cycle that a matching branch word is taken takes precedence, and that branch is not redirected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hint_valid_i | input | 1 | Hint command strobe |
| hint_branch_pc_i | input | 32 | Address of the hinted branch |
| hint_target_pc_i | input | 32 | Jump address of the hinted branch |
| mem_req_o | output | 1 | Instruction memory read request |
| mem_addr_o | output | 32 | Word address of the read request |
| mem_rdata_i | input | 32 | Read data, valid two cycles after its request |
| fetch_valid_o | output | 1 | A fetched word is offered |
| fetch_ready_i | input | 1 | Consumer takes the offered word |
| fetch_pc_o | output | 32 | Address of the offered word |
| fetch_instr_o | output | 32 | Offered instruction word |
| fetch_from_hint_o | output | 1 | Offered word comes from the target buffer |

## Verification
The hardest situations to reach from the ports are a hint that arrives too late, and a hint command that lands while the target buffer is still being drained. The late case is reached by pre-filling the prefetch queue with fetch_ready_i low. The bench then issues a hint whose branch is the word right after the one being taken, so the redirect starts before the first target word can return. The mid-drain case is reached with a self-looping hint whose jump address lies 16 bytes below its branch: the bench waits until the bench model reports the redirect as active, then issues a fresh hint. A cycle-level reference model in the bench tracks the expected address of every taken word through all of these cases.

// File: rtl/hfu_pkg.sv
package hfu_pkg;
  parameter int unsigned HFU_HTB_WORDS = 4;
  parameter int unsigned HFU_IDX_W     = $clog2(HFU_HTB_WORDS);
  parameter int unsigned HFU_EPOCH_W   = 2;

  typedef logic [HFU_EPOCH_W-1:0] epoch_t;

  // tag travelling beside each memory read
  typedef struct packed {
    logic                 vld;
    logic                 is_hint;
    logic [HFU_IDX_W-1:0] idx;
    epoch_t               epoch;
  } rd_tag_t;
endpackage

// File: rtl/hfu_fetch_fifo.sv
module hfu_fetch_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         flush_i,
  input  logic                         push_i,
  input  logic [W-1:0]                 din_i,
  input  logic                         pop_i,
  output logic [W-1:0]                 dout_o,
  output logic                         empty_o,
  output logic [$clog2(DEPTH+1)-1:0]   count_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] rd_ptr_q, wr_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign count_o = cnt_q;
  assign dout_o  = mem_q[rd_ptr_q];
  assign do_push = push_i && (cnt_q < CW'(DEPTH)) && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;

  function automatic logic [AW-1:0] inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= inc(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= inc(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= din_i;
  end
endmodule

// File: rtl/hfu_hint_buf.sv
module hfu_hint_buf #(
  parameter int unsigned W     = 32,
  parameter int unsigned WORDS = 4,
  parameter int unsigned IW    = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          wr_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [W-1:0]  rd_data_o,
  output logic          rd_vld_o
);
  logic [W-1:0]     data_q [WORDS];
  logic [WORDS-1:0] vld_q;

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic hit;
    assign hit = wr_i && (wr_idx_i == IW'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      vld_q[g] <= 1'b0;
      else if (clear_i) vld_q[g] <= 1'b0;
      else if (hit)     vld_q[g] <= 1'b1;
    end

    always_ff @(posedge clk_i) begin
      if (hit && !clear_i) data_q[g] <= wr_data_i;
    end
  end

  assign rd_data_o = data_q[rd_idx_i];
  assign rd_vld_o  = vld_q[rd_idx_i];
endmodule

// File: rtl/hfu_mem_port.sv
module hfu_mem_port
  import hfu_pkg::*;
#(
  parameter int unsigned AW  = 32,
  parameter int unsigned LAT = 2,
  parameter int unsigned IFW = $clog2(LAT+1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 fill_req_i,
  input  logic [AW-1:0]        fill_addr_i,
  input  logic [HFU_IDX_W-1:0] fill_idx_i,
  input  epoch_t               fill_epoch_i,
  input  logic                 pf_req_i,
  input  logic [AW-1:0]        pf_addr_i,
  input  epoch_t               pf_epoch_i,
  output logic                 fill_gnt_o,
  output logic                 pf_gnt_o,
  output logic                 mem_req_o,
  output logic [AW-1:0]        mem_addr_o,
  output rd_tag_t              ret_o,
  output logic [IFW-1:0]       inl_inflight_o
);
  rd_tag_t issue;
  rd_tag_t pipe_q [LAT];

  // target loads win the port
  assign fill_gnt_o = fill_req_i;
  assign pf_gnt_o   = pf_req_i && !fill_req_i;
  assign mem_req_o  = fill_req_i || pf_req_i;
  assign mem_addr_o = fill_req_i ? fill_addr_i : pf_addr_i;

  always_comb begin
    issue.vld     = mem_req_o;
    issue.is_hint = fill_req_i;
    issue.idx     = fill_req_i ? fill_idx_i : '0;
    issue.epoch   = fill_req_i ? fill_epoch_i : pf_epoch_i;
  end

  for (genvar s = 0; s < LAT; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     pipe_q[s] <= '0;
      else if (s == 0) pipe_q[s] <= issue;
      else             pipe_q[s] <= pipe_q[(s == 0) ? 0 : s-1];
    end
  end

  assign ret_o = pipe_q[LAT-1];

  always_comb begin
    inl_inflight_o = '0;
    for (int i = 0; i < LAT; i++) begin
      if (pipe_q[i].vld && !pipe_q[i].is_hint) inl_inflight_o = inl_inflight_o + 1'b1;
    end
  end
endmodule

// File: rtl/hint_fetch_unit.sv
module hint_fetch_unit
  import hfu_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned IPB_DEPTH  = 8,
  parameter int unsigned MEM_LAT    = 2,
  parameter logic [31:0] RESET_ADDR = 32'h0000_0100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hint_valid_i,
  input  logic [ADDR_W-1:0] hint_branch_pc_i,
  input  logic [ADDR_W-1:0] hint_target_pc_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              fetch_valid_o,
  input  logic              fetch_ready_i,
  output logic [ADDR_W-1:0] fetch_pc_o,
  output logic [DATA_W-1:0] fetch_instr_o,
  output logic              fetch_from_hint_o
);
  localparam int unsigned HTB_WORDS = HFU_HTB_WORDS;
  localparam int unsigned IW        = HFU_IDX_W;
  localparam int unsigned FPW       = $clog2(HTB_WORDS+1);
  localparam int unsigned CW        = $clog2(IPB_DEPTH+1);
  localparam int unsigned IFW       = $clog2(MEM_LAT+1);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(4*HTB_WORDS);

  // hint entry
  logic              hint_vld_q;
  logic [ADDR_W-1:0] br_q, tg_q;
  epoch_t            h_epoch_q;
  logic [FPW-1:0]    fill_ptr_q;
  // fetch state
  logic [ADDR_W-1:0] pc_q, pc_nxt;
  logic              hmode_q;
  logic [IW-1:0]     hptr_q;
  // prefetch state
  logic [ADDR_W-1:0] pf_addr_q;
  epoch_t            i_epoch_q;

  logic              accept, match, enter, leave, flush;
  logic              fill_req, fill_gnt, pf_req, pf_gnt;
  logic [ADDR_W-1:0] fill_addr;
  rd_tag_t           ret;
  logic [IFW-1:0]    inl_inflight;
  logic              ipb_empty;
  logic [CW-1:0]     ipb_cnt;
  logic [DATA_W-1:0] ipb_dout, htb_dout;
  logic              htb_vld;

  assign accept = fetch_valid_o && fetch_ready_i;
  assign match  = !hmode_q && hint_vld_q && !hint_valid_i && (pc_q == br_q);
  assign enter  = accept && match;
  assign leave  = accept && hmode_q && (hptr_q == IW'(HTB_WORDS-1));
  assign flush  = enter || (hint_valid_i && hmode_q);
  assign pc_nxt = !accept ? pc_q : (match ? tg_q : pc_q + STEP);

  assign fill_req  = hint_vld_q && (fill_ptr_q < FPW'(HTB_WORDS));
  assign fill_addr = tg_q + (ADDR_W'(fill_ptr_q) << 2);
  assign pf_req    = !flush && ((int'(ipb_cnt) + int'(inl_inflight)) < int'(IPB_DEPTH));

  hfu_mem_port #(
    .AW  (ADDR_W),
    .LAT (MEM_LAT),
    .IFW (IFW)
  ) u_port (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .fill_req_i     (fill_req),
    .fill_addr_i    (fill_addr),
    .fill_idx_i     (fill_ptr_q[IW-1:0]),
    .fill_epoch_i   (h_epoch_q),
    .pf_req_i       (pf_req),
    .pf_addr_i      (pf_addr_q),
    .pf_epoch_i     (i_epoch_q),
    .fill_gnt_o     (fill_gnt),
    .pf_gnt_o       (pf_gnt),
    .mem_req_o      (mem_req_o),
    .mem_addr_o     (mem_addr_o),
    .ret_o          (ret),
    .inl_inflight_o (inl_inflight)
  );

  hfu_fetch_fifo #(
    .W     (DATA_W),
    .DEPTH (IPB_DEPTH)
  ) u_ipb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush),
    .push_i  (ret.vld && !ret.is_hint && (ret.epoch == i_epoch_q)),
    .din_i   (mem_rdata_i),
    .pop_i   (accept && !hmode_q),
    .dout_o  (ipb_dout),
    .empty_o (ipb_empty),
    .count_o (ipb_cnt)
  );

  hfu_hint_buf #(
    .W     (DATA_W),
    .WORDS (HTB_WORDS),
    .IW    (IW)
  ) u_htb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (hint_valid_i),
    .wr_i      (ret.vld && ret.is_hint && (ret.epoch == h_epoch_q)),
    .wr_idx_i  (ret.idx),
    .wr_data_i (mem_rdata_i),
    .rd_idx_i  (hptr_q),
    .rd_data_o (htb_dout),
    .rd_vld_o  (htb_vld)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hint_vld_q <= 1'b0;
      br_q       <= '0;
      tg_q       <= '0;
      h_epoch_q  <= '0;
      fill_ptr_q <= FPW'(HTB_WORDS);
    end else if (hint_valid_i) begin
      hint_vld_q <= 1'b1;
      br_q       <= hint_branch_pc_i;
      tg_q       <= hint_target_pc_i;
      h_epoch_q  <= h_epoch_q + 1'b1;
      fill_ptr_q <= '0;
    end else if (fill_gnt) begin
      fill_ptr_q <= fill_ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= RESET_ADDR;
      hmode_q <= 1'b0;
      hptr_q  <= '0;
    end else begin
      pc_q <= pc_nxt;
      if (hint_valid_i || leave) hmode_q <= 1'b0;
      else if (enter)            hmode_q <= 1'b1;
      if (enter)                     hptr_q <= '0;
      else if (accept && hmode_q)    hptr_q <= hptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pf_addr_q <= RESET_ADDR;
      i_epoch_q <= '0;
    end else if (flush) begin
      pf_addr_q <= enter ? tg_q + SPAN : pc_nxt;
      i_epoch_q <= i_epoch_q + 1'b1;
    end else if (pf_gnt) begin
      pf_addr_q <= pf_addr_q + STEP;
    end
  end

  assign fetch_valid_o     = hmode_q ? htb_vld : !ipb_empty;
  assign fetch_pc_o        = pc_q;
  assign fetch_instr_o     = hmode_q ? htb_dout : ipb_dout;
  assign fetch_from_hint_o = hmode_q;
endmodule

// File: rtl/hfu_checker.sv
module hfu_checker #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned IPB_DEPTH = 8,
  parameter int unsigned HTB_WORDS = 4,
  parameter int unsigned FPW       = 3,
  parameter int unsigned CW        = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hint_valid_i,
  input logic [ADDR_W-1:0] hint_target_pc_i,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              fetch_valid_o,
  input logic              fetch_ready_i,
  input logic [ADDR_W-1:0] fetch_pc_o,
  input logic              fetch_from_hint_o,
  input logic              hint_vld_q,
  input logic [ADDR_W-1:0] br_q,
  input logic [ADDR_W-1:0] tg_q,
  input logic [FPW-1:0]    fill_ptr_q,
  input logic [CW-1:0]     ipb_cnt
);
  logic fill_pending, seq_take;
  assign fill_pending = hint_vld_q && (fill_ptr_q < FPW'(HTB_WORDS));
  assign seq_take = fetch_valid_o && fetch_ready_i && !fetch_from_hint_o &&
                    !(!hint_valid_i && hint_vld_q && (fetch_pc_o == br_q));

  a_r1_fill_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hint_valid_i |=> (mem_req_o && mem_addr_o == $past(hint_target_pc_i)));

  a_r6_fill_priority: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_pending |-> (mem_req_o && (mem_addr_o - tg_q) < ADDR_W'(4*HTB_WORDS)));

  a_r2_seq_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_take |=> (fetch_pc_o == $past(fetch_pc_o) + ADDR_W'(4)));

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_valid_o && !fetch_ready_i && !hint_valid_i) |=> (fetch_valid_o && $stable(fetch_pc_o)));

  a_r3_hint_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_from_hint_o |-> ((fetch_pc_o - tg_q) < ADDR_W'(4*HTB_WORDS)));

  a_r8_ipb_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ipb_cnt <= CW'(IPB_DEPTH));
endmodule

bind hint_fetch_unit hfu_checker #(
  .ADDR_W    (ADDR_W),
  .IPB_DEPTH (IPB_DEPTH),
  .HTB_WORDS (HTB_WORDS),
  .FPW       (FPW),
  .CW        (CW)
) u_chk (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .hint_valid_i      (hint_valid_i),
  .hint_target_pc_i  (hint_target_pc_i),
  .mem_req_o         (mem_req_o),
  .mem_addr_o        (mem_addr_o),
  .fetch_valid_o     (fetch_valid_o),
  .fetch_ready_i     (fetch_ready_i),
  .fetch_pc_o        (fetch_pc_o),
  .fetch_from_hint_o (fetch_from_hint_o),
  .hint_vld_q        (hint_vld_q),
  .br_q              (br_q),
  .tg_q              (tg_q),
  .fill_ptr_q        (fill_ptr_q),
  .ipb_cnt           (ipb_cnt)
);

// File: tb/tb_hint_fetch_unit.sv
module tb_hint_fetch_unit;
  localparam logic [31:0] RST_PC = 32'h0000_0100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hint_valid = 1'b0;
  logic [31:0] hint_br = '0, hint_tg = '0;
  logic        mem_req;
  logic [31:0] mem_addr, mem_rdata;
  logic        f_valid, f_ready = 1'b0, f_hint;
  logic [31:0] f_pc, f_instr;

  always #5 clk = ~clk;

  hint_fetch_unit #(.RESET_ADDR(RST_PC)) dut (
    .clk_i             (clk),
    .rst_ni            (rst_n),
    .hint_valid_i      (hint_valid),
    .hint_branch_pc_i  (hint_br),
    .hint_target_pc_i  (hint_tg),
    .mem_req_o         (mem_req),
    .mem_addr_o        (mem_addr),
    .mem_rdata_i       (mem_rdata),
    .fetch_valid_o     (f_valid),
    .fetch_ready_i     (f_ready),
    .fetch_pc_o        (f_pc),
    .fetch_instr_o     (f_instr),
    .fetch_from_hint_o (f_hint)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h1357_9BDF;
  endfunction

  // memory with two-cycle read latency
  logic [31:0] a1 = '0, a2 = '0;
  always @(posedge clk) begin
    a1 <= mem_addr;
    a2 <= a1;
  end
  assign mem_rdata = mem_word(a2);

  int unsigned req_cnt = 0;
  always @(posedge clk) if (rst_n && mem_req) req_cnt <= req_cnt + 1;

  int unsigned n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference model
  logic [31:0] m_pc = RST_PC, m_br = '0, m_tg = '0;
  bit          m_vld = 0, m_mode = 0;
  int unsigned m_k = 0, hint_words = 0, hint_stalls = 0;
  bit          pend_r1 = 0;
  logic [31:0] pend_tg = '0;

  task automatic step(input bit rdy, input bit hv, input logic [31:0] br, input logic [31:0] tg);
    bit take, mt;
    @(negedge clk);
    if (pend_r1) begin
      chk(mem_req && mem_addr == pend_tg, "R1 R6 first load", mem_addr, pend_tg);
      pend_r1 = 0;
    end
    hint_valid = hv; hint_br = br; hint_tg = tg; f_ready = rdy;
    if (f_valid) begin
      chk(f_pc == m_pc, m_mode ? "R3 pc" : "R2 pc", f_pc, m_pc);
      chk(f_instr == mem_word(m_pc), m_mode ? "R3 instr" : "R2 instr", f_instr, mem_word(m_pc));
      chk(f_hint == m_mode, "R3 source", {31'd0, f_hint}, {31'd0, m_mode});
    end else if (m_mode) begin
      hint_stalls++;
    end
    take = f_valid && rdy;
    if (take) begin
      if (m_mode) begin
        hint_words++;
        m_k++;
        m_pc = m_pc + 4;
        if (m_k == 4) m_mode = 0;
      end else begin
        mt = m_vld && (m_pc == m_br) && !hv;
        if (mt) begin m_mode = 1; m_k = 0; m_pc = m_tg; end
        else m_pc = m_pc + 4;
      end
    end
    if (hv) begin
      m_mode = 0; m_br = br; m_tg = tg; m_vld = 1;
      pend_r1 = 1; pend_tg = tg;
    end
  endtask

  task automatic run(input int n, input logic [3:0] pat);
    for (int i = 0; i < n; i++) step(pat[i % 4], 0, '0, '0);
  endtask

  int unsigned hw0, st0;

  initial begin
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!f_valid && !f_hint, "R9 reset outputs", {30'd0, f_valid, f_hint}, 32'd0);
    end
    rst_n = 1'b1;

    // R8: hold ready low, queue fills and prefetch stops
    run(30, 4'b0000);
    chk(req_cnt == 8, "R8 request count", req_cnt, 32'd8);
    chk(f_valid && f_pc == RST_PC, "R9 first pc", f_pc, RST_PC);

    // R2: sequential sweep under several ready patterns
    run(24, 4'b1111);
    run(24, 4'b1010);
    run(24, 4'b0110);
    run(24, 4'b0001);

    // R1/R3: early hint is fully effective
    hw0 = hint_words; st0 = hint_stalls;
    step(1, 1, m_pc + 64, 32'h0000_4000);
    run(40, 4'b1111);
    chk(hint_words - hw0 == 4, "R3 redirected words", hint_words - hw0, 32'd4);
    chk(hint_stalls == st0, "R3 no stall on early hint", hint_stalls - st0, 32'd0);

    // R7: self-looping hint redirects on every pass
    hw0 = hint_words;
    step(1, 1, m_pc + 32, m_pc + 16);
    run(60, 4'b1101);
    chk(hint_words - hw0 >= 12, "R7 loop reuse", hint_words - hw0, 32'd12);

    // R10: new hint lands while target words are drained
    for (int i = 0; i < 20 && !m_mode; i++) step(1, 0, '0, '0);
    chk(m_mode == 1, "R10 in redirect", {31'd0, m_mode}, 32'd1);
    step(1, 1, m_pc + 800, 32'h0000_8000);
    hw0 = hint_words;
    run(20, 4'b1111);
    chk(hint_words == hw0 && !f_hint, "R10 redirect ended", hint_words - hw0, 32'd0);

    // R5: overwritten hint no longer redirects
    step(1, 1, m_pc + 40, 32'h0000_9000);
    run(3, 4'b1111);
    step(1, 1, m_pc + 600, 32'h0000_A000);
    hw0 = hint_words;
    run(30, 4'b1111);
    chk(hint_words == hw0, "R5 old hint dead", hint_words - hw0, 32'd0);

    // R4: late hint stalls until target words arrive
    run(12, 4'b0000);
    hw0 = hint_words; st0 = hint_stalls;
    step(1, 1, m_pc + 4, 32'h0000_C000);
    run(30, 4'b1111);
    chk(hint_stalls > st0, "R4 stall observed", hint_stalls - st0, 32'd1);
    chk(hint_words - hw0 == 4, "R4 words delivered", hint_words - hw0, 32'd4);

    // R10: hint in the same cycle as a matching branch wins
    run(12, 4'b0000);
    step(1, 1, m_pc + 4, 32'h0000_D000);
    hw0 = hint_words;
    step(1, 1, m_pc, 32'h0000_E000);
    run(10, 4'b1111);
    chk(hint_words == hw0, "R10 same-cycle precedence", hint_words - hw0, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule